// File: doc/BRIEF.md
# Indexed PLL clock register bank

This block is the register file that holds the clock settings of a clock-generating video DAC. Software reaches it through a three-port indexed interface, and only while the bank-select input is high. One port sets a read pointer, another sets a write pointer, and a data port transfers bytes. Every entry is two bytes: a multiplier byte (M), then a divider byte (N). The data port moves through them in that order and goes to the next entry after the N byte. When the bank-select input is low, the same ports belong to the colour palette, which lives outside this block, and the bank stays untouched.

The bank has these entries:
- two hard-wired read-only clocks, whose values let software identify the chip;
- one writable pixel clock;
- a writable memory clock;
- a one-byte PLL control register.

The block decodes the selected clock and the memory clock into the multiplier M and the two divider fields N1 and N2, and passes them to the PLL core. The output frequency is ref*(M+2)/((N1+2)*2^N2).

Top module: `pll_clk_bank`

## Requirements
- R1: After reset, both pointers are at index 0 on the M byte and `rdata_o` is 0x00. The programmable clock holds M=0x1B, N=0x41, the memory clock holds M=0x2E, N=0x23, and the control byte is 0x00.
- R2: `port_i` encoding: 1 = read index, 2 = write index, 3 = data, 0 = unused. A write to port 1 or 2 loads `wdata_i[3:0]` into that pointer and returns its byte select to the M byte. A read of port 1 or 2 returns that index zero-extended to 8 bits. Port 0 reads 0x00, and writes to it do nothing.
- R3: Each read of port 3 returns the M byte, then the N byte, of the entry at the read index; the read index advances by one after the N byte and wraps from 15 to 0. Entry 0 reads 0x28,0x61 and entry 1 reads 0x3D,0x62, so eight bytes from index 0 begin 0x28,0x61,0x3D,0x62.
- R4: Writes to port 3 step the write pointer in the same way. They store bits 6:0 into entry 2 (programmable clock) or entry 10 (memory clock), and bit 7 of those bytes reads back as 0. The M-byte slot of entry 14 holds the full 8-bit control byte.
- R5: Writes to entries 0 and 1, to unimplemented entries, and to the N-byte slot of entry 14 change no stored value, but still step the write pointer. Unimplemented entries and the N-byte slot of entry 14 read 0x00.
- R6: While `rs_pll_i` is low, reads and writes change no pointer or register, and a read returns 0x00 on `rdata_o`.
- R7: `clk_sel_i` = 0 / 1 / 2 or 3 selects fixed clock 0 / fixed clock 1 / the programmable clock. For that clock, `m_o` = M[6:0], `n1_o` = N[4:0] and `n2_o` = N[6:5]. The memory-clock fields and `pll_ctrl_o` are always driven from their entries.
- R8: `rdata_o` changes on the clock edge that samples a read strobe and holds otherwise. If a data read and a data write in the same cycle hit the same byte, the read returns the value from before the write.
- R9: The read and write pointers are independent: data writes and write-index loads never move the read pointer, and data reads never move the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs_pll_i | input | 1 | Bank select: high routes accesses to this bank |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| port_i | input | 2 | Port select (1 read index, 2 write index, 3 data) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| clk_sel_i | input | 2 | Selects the clock driven on m_o/n1_o/n2_o |
| m_o | output | 7 | Multiplier of selected clock |
| n1_o | output | 5 | Pre-divider of selected clock |
| n2_o | output | 2 | Post-divider exponent of selected clock |
| mclk_m_o | output | 7 | Memory clock multiplier |
| mclk_n1_o | output | 5 | Memory clock pre-divider |
| mclk_n2_o | output | 2 | Memory clock post-divider exponent |
| pll_ctrl_o | output | 8 | PLL control byte |

## Verification
A data read and a data write can fall in the same cycle, and the two pointers can be aimed at the same byte of the programmable clock when they do. The bench provokes this directly by loading both indices to 2 and strobing read and write together. It also lets the random phase assert both strobes freely. The reference model computes the read result from the state before the write, then applies the write and both pointer steps. A design that forwards the new byte, or that steps only one pointer, is caught by a value mismatch or by the next read.

// File: rtl/pll_bank_pkg.sv
package pll_bank_pkg;
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  localparam int M_W  = 7;
  localparam int N_W  = 7;
  localparam int N1_W = 5;
  localparam int N2_W = 2;

  localparam logic [M_W-1:0] FIX0_M = 7'h28;
  localparam logic [N_W-1:0] FIX0_N = 7'h61;
  localparam logic [M_W-1:0] FIX1_M = 7'h3D;
  localparam logic [N_W-1:0] FIX1_N = 7'h62;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } clk_ent_t;
endpackage

// File: rtl/pll_bank_ptr.sv
module pll_bank_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      hi_o  <= 1'b0;
    end else if (load_i) begin
      idx_o <= load_val_i;
      hi_o  <= 1'b0;
    end else if (step_i) begin
      hi_o <= ~hi_o;
      if (hi_o) idx_o <= idx_o + IDX_W'(1);
    end
  end

  a_r3_byte_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (hi_o != $past(hi_o)));
  a_r3_index_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && hi_o) |=> (idx_o == $past(idx_o) + IDX_W'(1)));
  a_r2_load_clears_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!hi_o && idx_o == $past(load_val_i)));
endmodule

// File: rtl/pll_bank_entry.sv
module pll_bank_entry
  import pll_bank_pkg::*;
#(
  parameter int             IDX_W   = 4,
  parameter int             ENT_IDX = 2,
  parameter logic [M_W-1:0] M_RST   = 7'h1B,
  parameter logic [N_W-1:0] N_RST   = 7'h41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             whi_i,
  input  logic [7:0]       wdata_i,
  output clk_ent_t         ent_o
);
  logic hit;
  assign hit = we_i && (widx_i == IDX_W'(ENT_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_o.m <= M_RST;
      ent_o.n <= N_RST;
    end else if (hit) begin
      if (whi_i) ent_o.n <= wdata_i[N_W-1:0];
      else       ent_o.m <= wdata_i[M_W-1:0];
    end
  end

  a_r4_m_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !whi_i) |=> (ent_o.m == $past(wdata_i[M_W-1:0])));
  a_r4_n_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && whi_i) |=> (ent_o.n == $past(wdata_i[N_W-1:0])));
  a_r5_hold_unaddressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(ent_o));
endmodule

// File: rtl/pll_bank_regs.sv
module pll_bank_regs
  import pll_bank_pkg::*;
#(
  parameter int             IDX_W      = 4,
  parameter int             PROG_IDX   = 2,
  parameter int             MCLK_IDX   = 10,
  parameter int             CTRL_IDX   = 14,
  parameter logic [M_W-1:0] PROG_M_RST = 7'h1B,
  parameter logic [N_W-1:0] PROG_N_RST = 7'h41,
  parameter logic [M_W-1:0] MCLK_M_RST = 7'h2E,
  parameter logic [N_W-1:0] MCLK_N_RST = 7'h23,
  parameter logic [7:0]     CTRL_RST   = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             whi_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic             rhi_i,
  output logic [7:0]       rbyte_o,
  output clk_ent_t         prog_o,
  output clk_ent_t         mclk_o,
  output logic [7:0]       ctrl_o
);
  localparam int NUM_WR = 2;
  localparam int WR_IDX_0 = PROG_IDX;
  localparam int WR_IDX_1 = MCLK_IDX;

  clk_ent_t wr_ent [NUM_WR];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_ent
    localparam int             EIDX = (g == 0) ? WR_IDX_0 : WR_IDX_1;
    localparam logic [M_W-1:0] EM   = (g == 0) ? PROG_M_RST : MCLK_M_RST;
    localparam logic [N_W-1:0] EN   = (g == 0) ? PROG_N_RST : MCLK_N_RST;
    pll_bank_entry #(
      .IDX_W(IDX_W), .ENT_IDX(EIDX), .M_RST(EM), .N_RST(EN)
    ) i_ent (
      .clk_i, .rst_ni, .we_i, .widx_i, .whi_i, .wdata_i,
      .ent_o(wr_ent[g])
    );
  end

  assign prog_o = wr_ent[0];
  assign mclk_o = wr_ent[1];

  logic ctrl_hit;
  assign ctrl_hit = we_i && !whi_i && (widx_i == IDX_W'(CTRL_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_o <= CTRL_RST;
    else if (ctrl_hit) ctrl_o <= wdata_i;
  end

  function automatic logic [7:0] pick(input clk_ent_t e, input logic hi);
    return hi ? {1'b0, e.n} : {1'b0, e.m};
  endfunction

  always_comb begin
    rbyte_o = 8'h00;
    if (ridx_i == IDX_W'(0))             rbyte_o = pick({FIX0_M, FIX0_N}, rhi_i);
    else if (ridx_i == IDX_W'(1))        rbyte_o = pick({FIX1_M, FIX1_N}, rhi_i);
    else if (ridx_i == IDX_W'(PROG_IDX)) rbyte_o = pick(prog_o, rhi_i);
    else if (ridx_i == IDX_W'(MCLK_IDX)) rbyte_o = pick(mclk_o, rhi_i);
    else if (ridx_i == IDX_W'(CTRL_IDX)) rbyte_o = rhi_i ? 8'h00 : ctrl_o;
  end

  a_r4_ctrl_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> (ctrl_o == $past(wdata_i)));
  a_r5_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_hit |=> $stable(ctrl_o));
endmodule

// File: rtl/pll_clk_bank.sv
module pll_clk_bank
  import pll_bank_pkg::*;
#(
  parameter int             IDX_W      = 4,
  parameter int             PROG_IDX   = 2,
  parameter int             MCLK_IDX   = 10,
  parameter int             CTRL_IDX   = 14,
  parameter logic [M_W-1:0] PROG_M_RST = 7'h1B,
  parameter logic [N_W-1:0] PROG_N_RST = 7'h41,
  parameter logic [M_W-1:0] MCLK_M_RST = 7'h2E,
  parameter logic [N_W-1:0] MCLK_N_RST = 7'h23,
  parameter logic [7:0]     CTRL_RST   = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rs_pll_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [1:0]  port_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [1:0]  clk_sel_i,
  output logic [6:0]  m_o,
  output logic [4:0]  n1_o,
  output logic [1:0]  n2_o,
  output logic [6:0]  mclk_m_o,
  output logic [4:0]  mclk_n1_o,
  output logic [1:0]  mclk_n2_o,
  output logic [7:0]  pll_ctrl_o
);
  localparam int RD = 0;
  localparam int WR = 1;

  logic acc_rd, acc_wr;
  assign acc_rd = rd_en_i && rs_pll_i;
  assign acc_wr = wr_en_i && rs_pll_i;

  logic [IDX_W-1:0] ptr_idx [2];
  logic [1:0]       ptr_hi, ptr_ld, ptr_st;

  assign ptr_ld[RD] = acc_wr && (port_i == PORT_RIDX);
  assign ptr_ld[WR] = acc_wr && (port_i == PORT_WIDX);
  assign ptr_st[RD] = acc_rd && (port_i == PORT_DATA);
  assign ptr_st[WR] = acc_wr && (port_i == PORT_DATA);

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    pll_bank_ptr #(.IDX_W(IDX_W)) i_ptr (
      .clk_i, .rst_ni,
      .load_i    (ptr_ld[g]),
      .load_val_i(wdata_i[IDX_W-1:0]),
      .step_i    (ptr_st[g]),
      .idx_o     (ptr_idx[g]),
      .hi_o      (ptr_hi[g])
    );
  end

  logic [7:0] rbyte;
  clk_ent_t   prog_ent, mclk_ent;

  pll_bank_regs #(
    .IDX_W(IDX_W), .PROG_IDX(PROG_IDX), .MCLK_IDX(MCLK_IDX), .CTRL_IDX(CTRL_IDX),
    .PROG_M_RST(PROG_M_RST), .PROG_N_RST(PROG_N_RST),
    .MCLK_M_RST(MCLK_M_RST), .MCLK_N_RST(MCLK_N_RST), .CTRL_RST(CTRL_RST)
  ) i_regs (
    .clk_i, .rst_ni,
    .we_i   (ptr_st[WR]),
    .widx_i (ptr_idx[WR]),
    .whi_i  (ptr_hi[WR]),
    .wdata_i,
    .ridx_i (ptr_idx[RD]),
    .rhi_i  (ptr_hi[RD]),
    .rbyte_o(rbyte),
    .prog_o (prog_ent),
    .mclk_o (mclk_ent),
    .ctrl_o (pll_ctrl_o)
  );

  logic [7:0] rd_next;
  always_comb begin
    rd_next = 8'h00;
    if (rs_pll_i) begin
      unique case (port_i)
        PORT_RIDX: rd_next = 8'(ptr_idx[RD]);
        PORT_WIDX: rd_next = 8'(ptr_idx[WR]);
        PORT_DATA: rd_next = rbyte;
        default:   rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= 8'h00;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  clk_ent_t sel_ent;
  always_comb begin
    unique case (clk_sel_i)
      2'd0:    sel_ent = '{m: FIX0_M, n: FIX0_N};
      2'd1:    sel_ent = '{m: FIX1_M, n: FIX1_N};
      default: sel_ent = prog_ent;
    endcase
  end

  assign m_o       = sel_ent.m;
  assign n1_o      = sel_ent.n[N1_W-1:0];
  assign n2_o      = sel_ent.n[N1_W+N2_W-1:N1_W];
  assign mclk_m_o  = mclk_ent.m;
  assign mclk_n1_o = mclk_ent.n[N1_W-1:0];
  assign mclk_n2_o = mclk_ent.n[N1_W+N2_W-1:N1_W];

  a_r6_deselected_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_pll_i |=> ($stable(ptr_idx[RD]) && $stable(ptr_idx[WR]) && $stable(ptr_hi)
                   && $stable(pll_ctrl_o) && $stable(prog_ent) && $stable(mclk_ent)));
  a_r6_deselected_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rs_pll_i) |=> (rdata_o == 8'h00));
  a_r8_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  a_r8_read_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && acc_wr && port_i == PORT_DATA && ptr_idx[RD] == ptr_idx[WR]
     && ptr_hi[RD] == ptr_hi[WR]) |=> (rdata_o == $past(rbyte)));
  a_r9_write_keeps_read_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_ld[RD] && !ptr_st[RD]) |=> ($stable(ptr_idx[RD]) && $stable(ptr_hi[RD])));
  a_r9_read_keeps_write_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_ld[WR] && !ptr_st[WR]) |=> ($stable(ptr_idx[WR]) && $stable(ptr_hi[WR])));
endmodule

// File: tb/test_pll_clk_bank.sv
module test_pll_clk_bank;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, rs, rd, wr;
  logic [1:0] port, csel;
  logic [7:0] wdata, rdata;
  logic [6:0] m, mc_m;
  logic [4:0] n1, mc_n1;
  logic [1:0] n2, mc_n2;
  logic [7:0] ctrl;

  pll_clk_bank i_pll_clk_bank (
    .clk_i(clk), .rst_ni(rst_n), .rs_pll_i(rs), .rd_en_i(rd), .wr_en_i(wr),
    .port_i(port), .wdata_i(wdata), .rdata_o(rdata), .clk_sel_i(csel),
    .m_o(m), .n1_o(n1), .n2_o(n2), .mclk_m_o(mc_m), .mclk_n1_o(mc_n1),
    .mclk_n2_o(mc_n2), .pll_ctrl_o(ctrl)
  );

  int n_tests = 0, n_fail = 0;

  logic [6:0] p_m, p_n, k_m, k_n;
  logic [7:0] x_ctrl;
  logic [3:0] r_idx, w_idx;
  logic       r_hi, w_hi;

  function automatic logic [7:0] exp_byte(input logic [3:0] i, input logic h);
    case (i)
      4'd0:    return h ? 8'h61 : 8'h28;
      4'd1:    return h ? 8'h62 : 8'h3D;
      4'd2:    return h ? {1'b0, p_n} : {1'b0, p_m};
      4'd10:   return h ? {1'b0, k_n} : {1'b0, k_m};
      4'd14:   return h ? 8'h00 : x_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic s, input logic r, input logic w, input logic [1:0] p,
                    input logic [7:0] d, input string tag);
    logic [7:0] e;
    e = 8'h00;
    if (s && r) begin
      case (p)
        2'd1:    e = {4'b0, r_idx};
        2'd2:    e = {4'b0, w_idx};
        2'd3:    e = exp_byte(r_idx, r_hi);
        default: e = 8'h00;
      endcase
    end
    @(negedge clk);
    rs = s; rd = r; wr = w; port = p; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    if (r) check(tag, rdata, e);
    if (s && w) begin
      case (p)
        2'd1: begin r_idx = d[3:0]; r_hi = 1'b0; end
        2'd2: begin w_idx = d[3:0]; w_hi = 1'b0; end
        2'd3: begin
          if (w_idx == 4'd2)       begin if (w_hi) p_n = d[6:0]; else p_m = d[6:0]; end
          else if (w_idx == 4'd10) begin if (w_hi) k_n = d[6:0]; else k_m = d[6:0]; end
          else if (w_idx == 4'd14 && !w_hi) x_ctrl = d;
          if (w_hi) w_idx = w_idx + 4'd1;
          w_hi = ~w_hi;
        end
        default: ;
      endcase
    end
    if (s && r && p == 2'd3) begin
      if (r_hi) r_idx = r_idx + 4'd1;
      r_hi = ~r_hi;
    end
  endtask

  task automatic chk_out(input string tag);
    for (int s = 0; s < 4; s++) begin
      logic [6:0] em, en;
      @(negedge clk);
      csel = 2'(s);
      #1;
      em = (s == 0) ? 7'h28 : (s == 1) ? 7'h3D : p_m;
      en = (s == 0) ? 7'h61 : (s == 1) ? 7'h62 : p_n;
      check({tag, " m"},  m,  em);
      check({tag, " n1"}, n1, en[4:0]);
      check({tag, " n2"}, n2, en[6:5]);
    end
    check({tag, " mclk m"},  mc_m,  k_m);
    check({tag, " mclk n1"}, mc_n1, k_n[4:0]);
    check({tag, " mclk n2"}, mc_n2, k_n[6:5]);
    check({tag, " ctrl"},    ctrl,  x_ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rs = 1'b0; rd = 1'b0; wr = 1'b0; port = 2'd0; wdata = 8'h00; csel = 2'd0;
    p_m = 7'h1B; p_n = 7'h41; k_m = 7'h2E; k_n = 7'h23; x_ctrl = 8'h00;
    r_idx = 4'd0; w_idx = 4'd0; r_hi = 1'b0; w_hi = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdata reset", rdata, 8'h00);
    rst_n = 1'b1;
    chk_out("R1 reset outputs");
    op(1, 1, 0, 2'd1, 8'h00, "R1 read index reset");
    op(1, 1, 0, 2'd2, 8'h00, "R1 write index reset");

    // R3: eight bytes from index 0
    for (int i = 0; i < 8; i++) op(1, 1, 0, 2'd3, 8'h00, "R3 sequential read");
    op(1, 1, 0, 2'd1, 8'h00, "R3 index after 8 bytes");
    // R3 wrap from 15
    op(1, 0, 1, 2'd1, 8'hFF, "R2 load read index");
    op(1, 1, 0, 2'd1, 8'h00, "R2 readback upper bits dropped");
    op(1, 1, 0, 2'd3, 8'h00, "R3 read idx15 M");
    op(1, 1, 0, 2'd3, 8'h00, "R3 read idx15 N");
    op(1, 1, 0, 2'd1, 8'h00, "R3 index wraps to 0");

    // R4: program clock, memory clock, control
    op(1, 0, 1, 2'd2, 8'h02, "R4 write index");
    op(1, 0, 1, 2'd3, 8'hC5, "R4 prog M");
    op(1, 0, 1, 2'd3, 8'hFF, "R4 prog N");
    op(1, 1, 0, 2'd2, 8'h00, "R4 write index advanced");
    op(1, 0, 1, 2'd2, 8'h0A, "R4 write index mclk");
    op(1, 0, 1, 2'd3, 8'h55, "R4 mclk M");
    op(1, 0, 1, 2'd3, 8'h3A, "R4 mclk N");
    op(1, 0, 1, 2'd2, 8'h0E, "R4 write index ctrl");
    op(1, 0, 1, 2'd3, 8'hA7, "R4 ctrl byte");
    op(1, 0, 1, 2'd3, 8'h99, "R5 ctrl N slot ignored");
    chk_out("R7 programmed outputs");
    op(1, 0, 1, 2'd1, 8'h02, "R4 read index prog");
    op(1, 1, 0, 2'd3, 8'h00, "R4 prog M bit7 clear");
    op(1, 1, 0, 2'd3, 8'h00, "R4 prog N bit7 clear");

    // R5: fixed entries ignore writes
    op(1, 0, 1, 2'd2, 8'h00, "R5 write index 0");
    for (int i = 0; i < 4; i++) op(1, 0, 1, 2'd3, 8'h11, "R5 write fixed");
    op(1, 1, 0, 2'd2, 8'h00, "R5 write pointer stepped");
    op(1, 0, 1, 2'd1, 8'h00, "R5 read index 0");
    for (int i = 0; i < 4; i++) op(1, 1, 0, 2'd3, 8'h00, "R5 fixed unchanged");
    op(1, 1, 0, 2'd0, 8'h00, "R2 port0 reads zero");

    // R6: deselected
    op(0, 0, 1, 2'd1, 8'h07, "R6 deselected index write");
    op(0, 1, 1, 2'd3, 8'h33, "R6 deselected read zero");
    op(1, 1, 0, 2'd1, 8'h00, "R6 read index unchanged");
    op(1, 1, 0, 2'd2, 8'h00, "R6 write index unchanged");
    chk_out("R6 outputs unchanged");

    // R8/R9: concurrent read and write on same byte
    op(1, 0, 1, 2'd1, 8'h02, "R9 load read index");
    op(1, 0, 1, 2'd2, 8'h02, "R9 load write index");
    op(1, 1, 1, 2'd3, 8'h12, "R8 concurrent M returns old");
    op(1, 1, 1, 2'd3, 8'h34, "R8 concurrent N returns old");
    op(1, 1, 0, 2'd1, 8'h00, "R9 read index stepped once");
    op(1, 0, 1, 2'd1, 8'h02, "R9 reload read index");
    op(1, 1, 0, 2'd3, 8'h00, "R8 new M visible");
    chk_out("R7 after concurrent");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, r, w;
      logic [1:0] p;
      logic [7:0] d;
      s = ($urandom % 8) != 0;
      r = $urandom % 2;
      w = $urandom % 2;
      p = 2'($urandom % 4);
      d = 8'($urandom);
      if (p != 2'd3 && w && ($urandom % 3) == 0) d = ($urandom % 2) ? 8'h02 : 8'h0A;
      op(s, r, w, p, d, "R2 R3 R4 R5 R6 R8 R9 random");
      if (i % 16 == 0) chk_out("R7 random outputs");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule